// File: doc/BRIEF.md
# Reset Cause and Sleep Controller

This block sits next to a small 8-bit processor core and owns everything that happens around a restart. It watches three restart sources (power-on, an external master-clear pin and a watchdog timeout) and picks one of them when several are active together. On any restart it raises a core reset for one cycle and tells the program counter to load the reset vector, the top word of a 2K-word program store. It also records why the core restarted in two status bits: a timeout flag (TO) and a power-down flag (PD).

The block decodes the two 14-bit instruction words that act on it. Clear-watchdog restarts the watchdog count. Sleep restarts the count and gates the core clock off until a restart arrives. The watchdog counter advances on its own free-running tick enable, so it keeps counting while the core sleeps. On overflow it requests a watchdog restart, and that restart wakes the core.

Top module: `rsc_ctrl`

## Requirements
- R1: While `por_i` is high at a clock edge, TO and PD become 1, the sleeping state clears, and `core_rst_o` is high in the following cycle.
- R2: Any restart (power-on, master-clear or watchdog) drives `core_rst_o` and `pc_load_o` high for exactly the cycle after the edge that saw it. `pc_vec_o` is always 0x7FF.
- R3: A master-clear restart while the core is awake leaves TO and PD unchanged.
- R4: A master-clear restart while the core is asleep sets TO=1 and PD=0 and wakes the core.
- R5: A watchdog restart while the core is awake sets TO=0 and PD=1.
- R6: A watchdog restart while the core is asleep sets TO=0 and PD=0 and wakes the core.
- R7: The instruction word 14'h1001 (clear-watchdog) sets TO=1 and PD=1 and restarts the watchdog count from zero.
- R8: The instruction word 14'h1002 (sleep) sets TO=1 and PD=0, restarts the watchdog count, raises `sleeping_o` and drops `core_clk_en_o` from the next cycle on.
- R9: The word 14'h1000 (no-operation) and every word other than 14'h1001 and 14'h1002 leave TO, PD and the sleeping state unchanged.
- R10: When sources coincide, power-on wins over master-clear, and master-clear wins over watchdog.
- R11: The watchdog count advances once per cycle with `wdt_tick_i` high. `wdt_ovf_o` is high while the count is at its maximum and a tick is present, and this overflow is treated as a watchdog restart in the same cycle.
- R12: While asleep, or when `instr_valid_i` is low, instruction words have no effect on TO, PD, the sleeping state or the watchdog count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_i | input | 1 | Power-on restart, also the synchronous reset |
| mclr_i | input | 1 | External master-clear restart |
| wdt_timeout_i | input | 1 | External watchdog timeout request |
| wdt_tick_i | input | 1 | Free-running watchdog count enable |
| instr_valid_i | input | 1 | Instruction word is being executed |
| instr_i | input | 14 | Instruction word |
| core_rst_o | output | 1 | One-cycle core reset |
| pc_load_o | output | 1 | Program counter loads `pc_vec_o` |
| pc_vec_o | output | PC_W (11) | Reset vector |
| core_clk_en_o | output | 1 | Core clock enable, low while asleep |
| sleeping_o | output | 1 | Core is asleep |
| to_flag_o | output | 1 | Timeout flag |
| pd_flag_o | output | 1 | Power-down flag |
| wdt_ovf_o | output | 1 | Watchdog overflow restart request |

## Verification
A wrong sleeping state shows at the ports one cycle after the edge that set it. It appears through `core_clk_en_o` and `sleeping_o`, and also as the wrong PD value after the next master-clear or watchdog restart, because both of those flag outcomes depend on whether the core was asleep. A watchdog count that is off by one, or that was not cleared, becomes visible only when the overflow comes one tick early or late. The bench therefore clears the count and counts ticks to the exact overflow edge, both awake and asleep. Priority faults show as wrong flag pairs in the cycle after coinciding sources.

// File: rtl/rsc_pkg.sv
package rsc_pkg;

    localparam int unsigned INSTR_W = 14;

    localparam logic [INSTR_W-1:0] WORD_NOP    = 14'h1000;
    localparam logic [INSTR_W-1:0] WORD_CLRWDT = 14'h1001;
    localparam logic [INSTR_W-1:0] WORD_SLEEP  = 14'h1002;

    typedef enum logic [1:0] {
        CAUSE_NONE = 2'd0,
        CAUSE_POR  = 2'd1,
        CAUSE_MCLR = 2'd2,
        CAUSE_WDT  = 2'd3
    } cause_e;

    typedef enum logic [1:0] {
        CMD_NONE   = 2'd0,
        CMD_CLRWDT = 2'd1,
        CMD_SLEEP  = 2'd2
    } cmd_e;

    typedef struct packed {
        logic to;
        logic pd;
    } flags_t;

    typedef struct packed {
        flags_t flags;
        logic   asleep;
    } pstate_t;

    // Next flag/sleep state from the winning restart cause and command.
    function automatic pstate_t next_state(cause_e c, cmd_e k, pstate_t cur);
        pstate_t n;
        n = cur;
        case (c)
            CAUSE_POR: begin
                n.flags.to = 1'b1;
                n.flags.pd = 1'b1;
                n.asleep   = 1'b0;
            end
            CAUSE_MCLR: begin
                if (cur.asleep) begin
                    n.flags.to = 1'b1;
                    n.flags.pd = 1'b0;
                end
                n.asleep = 1'b0;
            end
            CAUSE_WDT: begin
                n.flags.to = 1'b0;
                n.flags.pd = ~cur.asleep;
                n.asleep   = 1'b0;
            end
            default: begin
                case (k)
                    CMD_CLRWDT: begin
                        n.flags.to = 1'b1;
                        n.flags.pd = 1'b1;
                    end
                    CMD_SLEEP: begin
                        n.flags.to = 1'b1;
                        n.flags.pd = 1'b0;
                        n.asleep   = 1'b1;
                    end
                    default: n = cur;
                endcase
            end
        endcase
        return n;
    endfunction

endpackage

// File: rtl/rsc_cause_arb.sv
module rsc_cause_arb
    import rsc_pkg::*;
(
    input  logic   clk,
    input  logic   por_i,
    input  logic   mclr_i,
    input  logic   wdt_i,
    output cause_e cause_o
);

    always_comb begin
        if (por_i)       cause_o = CAUSE_POR;
        else if (mclr_i) cause_o = CAUSE_MCLR;
        else if (wdt_i)  cause_o = CAUSE_WDT;
        else             cause_o = CAUSE_NONE;
    end

    // R10
    mclr_over_wdt_chk: assert property (@(posedge clk) disable iff (por_i)
        mclr_i |-> cause_o == CAUSE_MCLR);

    // R10
    wdt_lowest_chk: assert property (@(posedge clk) disable iff (por_i)
        (wdt_i && !mclr_i) |-> cause_o == CAUSE_WDT);

endmodule

// File: rtl/rsc_instr_dec.sv
module rsc_instr_dec
    import rsc_pkg::*;
(
    input  logic               valid_i,
    input  logic               asleep_i,
    input  logic [INSTR_W-1:0] instr_i,
    output cmd_e               cmd_o
);

    logic live;
    assign live = valid_i & ~asleep_i;

    always_comb begin
        cmd_o = CMD_NONE;
        if (live) begin
            case (instr_i)
                WORD_CLRWDT: cmd_o = CMD_CLRWDT;
                WORD_SLEEP:  cmd_o = CMD_SLEEP;
                default:     cmd_o = CMD_NONE;
            endcase
        end
    end

endmodule

// File: rtl/rsc_watchdog.sv
module rsc_watchdog #(
    parameter int unsigned WDT_W = 8
) (
    input  logic clk,
    input  logic rst_i,
    input  logic clr_i,
    input  logic tick_i,
    output logic ovf_o
);

    localparam logic [WDT_W-1:0] CNT_MAX = {WDT_W{1'b1}};

    logic [WDT_W-1:0] cnt_q;

    assign ovf_o = tick_i & (cnt_q == CNT_MAX);

    always_ff @(posedge clk) begin
        if (rst_i || clr_i) cnt_q <= '0;
        else if (tick_i)    cnt_q <= cnt_q + 1'b1;
    end

    // R7
    clear_zero_chk: assert property (@(posedge clk) disable iff (rst_i)
        clr_i |=> cnt_q == '0);

    // R11
    tick_step_chk: assert property (@(posedge clk) disable iff (rst_i)
        (tick_i && !clr_i) |=> cnt_q == WDT_W'($past(cnt_q) + 1'b1));

    // R12
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst_i)
        (!tick_i && !clr_i) |=> $stable(cnt_q));

endmodule

// File: rtl/rsc_state.sv
module rsc_state
    import rsc_pkg::*;
(
    input  logic    clk,
    input  logic    rst_i,
    input  cause_e  cause_i,
    input  cmd_e    cmd_i,
    output pstate_t state_o
);

    pstate_t state_q;

    always_ff @(posedge clk) begin
        if (rst_i) begin
            state_q.flags.to <= 1'b1;
            state_q.flags.pd <= 1'b1;
            state_q.asleep   <= 1'b0;
        end else begin
            state_q <= next_state(cause_i, cmd_i, state_q);
        end
    end

    assign state_o = state_q;

    // R3
    mclr_awake_chk: assert property (@(posedge clk) disable iff (rst_i)
        (cause_i == CAUSE_MCLR && !state_q.asleep) |=> $stable(state_q.flags) && !state_q.asleep);

    // R4
    mclr_asleep_chk: assert property (@(posedge clk) disable iff (rst_i)
        (cause_i == CAUSE_MCLR && state_q.asleep) |=> state_q.flags.to && !state_q.flags.pd && !state_q.asleep);

    // R5
    wdt_awake_chk: assert property (@(posedge clk) disable iff (rst_i)
        (cause_i == CAUSE_WDT && !state_q.asleep) |=> !state_q.flags.to && state_q.flags.pd);

    // R6
    wdt_asleep_chk: assert property (@(posedge clk) disable iff (rst_i)
        (cause_i == CAUSE_WDT && state_q.asleep) |=> !state_q.flags.to && !state_q.flags.pd && !state_q.asleep);

    // R8
    sleep_enter_chk: assert property (@(posedge clk) disable iff (rst_i)
        (cause_i == CAUSE_NONE && cmd_i == CMD_SLEEP) |=> state_q.asleep && state_q.flags.to && !state_q.flags.pd);

    // R12
    sleep_hold_chk: assert property (@(posedge clk) disable iff (rst_i)
        (cause_i == CAUSE_NONE && state_q.asleep) |=> state_q.asleep && $stable(state_q.flags));

endmodule

// File: rtl/rsc_ctrl.sv
module rsc_ctrl
    import rsc_pkg::*;
#(
    parameter int unsigned     WDT_W     = 8,
    parameter int unsigned     PC_W      = 11,
    parameter logic [PC_W-1:0] RESET_VEC = {PC_W{1'b1}}
) (
    input  logic               clk,
    input  logic               por_i,
    input  logic               mclr_i,
    input  logic               wdt_timeout_i,
    input  logic               wdt_tick_i,
    input  logic               instr_valid_i,
    input  logic [INSTR_W-1:0] instr_i,
    output logic               core_rst_o,
    output logic               pc_load_o,
    output logic [PC_W-1:0]    pc_vec_o,
    output logic               core_clk_en_o,
    output logic               sleeping_o,
    output logic               to_flag_o,
    output logic               pd_flag_o,
    output logic               wdt_ovf_o
);

    cause_e  cause;
    cmd_e    cmd;
    pstate_t pst;
    logic    wdt_ovf;
    logic    wdt_fire;
    logic    wdt_clr;
    logic    rst_pulse_q;

    assign wdt_fire = wdt_timeout_i | wdt_ovf;

    rsc_cause_arb u_arb (
        .clk     (clk),
        .por_i   (por_i),
        .mclr_i  (mclr_i),
        .wdt_i   (wdt_fire),
        .cause_o (cause)
    );

    rsc_instr_dec u_dec (
        .valid_i  (instr_valid_i),
        .asleep_i (pst.asleep),
        .instr_i  (instr_i),
        .cmd_o    (cmd)
    );

    assign wdt_clr = (cause != CAUSE_NONE) | (cmd != CMD_NONE);

    rsc_watchdog #(.WDT_W(WDT_W)) u_wdt (
        .clk    (clk),
        .rst_i  (por_i),
        .clr_i  (wdt_clr),
        .tick_i (wdt_tick_i),
        .ovf_o  (wdt_ovf)
    );

    rsc_state u_state (
        .clk     (clk),
        .rst_i   (por_i),
        .cause_i (cause),
        .cmd_i   (cmd),
        .state_o (pst)
    );

    always_ff @(posedge clk) begin
        if (por_i) rst_pulse_q <= 1'b1;
        else       rst_pulse_q <= mclr_i | wdt_fire;
    end

    assign core_rst_o    = rst_pulse_q;
    assign pc_load_o     = rst_pulse_q;
    assign pc_vec_o      = RESET_VEC;
    assign core_clk_en_o = ~pst.asleep;
    assign sleeping_o    = pst.asleep;
    assign to_flag_o     = pst.flags.to;
    assign pd_flag_o     = pst.flags.pd;
    assign wdt_ovf_o     = wdt_ovf;

    // R2
    restart_pulse_chk: assert property (@(posedge clk) disable iff (por_i)
        (mclr_i || wdt_timeout_i || wdt_ovf_o) |=> core_rst_o && pc_load_o);

    // R2
    quiet_no_pulse_chk: assert property (@(posedge clk) disable iff (por_i)
        !(mclr_i || wdt_timeout_i || wdt_ovf_o) |=> !core_rst_o);

    // R8
    clk_gate_chk: assert property (@(posedge clk) disable iff (por_i)
        core_clk_en_o == !sleeping_o);

endmodule

// File: tb/test_rsc_ctrl.sv
module test_rsc_ctrl;

    localparam int unsigned WW = 4;
    localparam int unsigned WMAX = (1 << WW) - 1;

    logic        clk = 1'b0;
    logic        por_i = 1'b1;
    logic        mclr_i = 1'b0;
    logic        wdt_timeout_i = 1'b0;
    logic        wdt_tick_i = 1'b0;
    logic        instr_valid_i = 1'b0;
    logic [13:0] instr_i = 14'h0000;
    logic        core_rst_o, pc_load_o, core_clk_en_o, sleeping_o;
    logic        to_flag_o, pd_flag_o, wdt_ovf_o;
    logic [10:0] pc_vec_o;

    always #5 clk = ~clk;

    rsc_ctrl #(.WDT_W(WW)) i_rsc_ctrl (
        .clk           (clk),
        .por_i         (por_i),
        .mclr_i        (mclr_i),
        .wdt_timeout_i (wdt_timeout_i),
        .wdt_tick_i    (wdt_tick_i),
        .instr_valid_i (instr_valid_i),
        .instr_i       (instr_i),
        .core_rst_o    (core_rst_o),
        .pc_load_o     (pc_load_o),
        .pc_vec_o      (pc_vec_o),
        .core_clk_en_o (core_clk_en_o),
        .sleeping_o    (sleeping_o),
        .to_flag_o     (to_flag_o),
        .pd_flag_o     (pd_flag_o),
        .wdt_ovf_o     (wdt_ovf_o)
    );

    typedef struct {
        logic  to;
        logic  pd;
        logic  slp;
        logic  rst;
        string tag;
    } exp_t;

    exp_t q[$];
    int   checks = 0;
    int   errors = 0;
    logic m_to = 1'b1, m_pd = 1'b1, m_slp = 1'b0;
    int   m_cnt = 0;

    task automatic check(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // Driver: applies one cycle of stimulus and queues the expected result.
    task automatic step(input logic p, input logic m, input logic w, input logic t,
                        input logic v, input logic [13:0] ins, input string tag);
        logic fire, rst;
        exp_t e;
        @(negedge clk);
        por_i = p; mclr_i = m; wdt_timeout_i = w; wdt_tick_i = t;
        instr_valid_i = v; instr_i = ins;
        #1;
        check(tag, "wdt_ovf", int'(wdt_ovf_o), int'(t && m_cnt == WMAX));
        @(posedge clk);
        fire = w || (t && m_cnt == WMAX);
        rst = p || m || fire;
        if (p) begin
            m_to = 1; m_pd = 1; m_slp = 0; m_cnt = 0;
        end else if (m) begin
            if (m_slp) begin m_to = 1; m_pd = 0; end
            m_slp = 0; m_cnt = 0;
        end else if (fire) begin
            m_to = 0; m_pd = !m_slp; m_slp = 0; m_cnt = 0;
        end else if (v && !m_slp && ins == 14'h1001) begin
            m_to = 1; m_pd = 1; m_cnt = 0;
        end else if (v && !m_slp && ins == 14'h1002) begin
            m_to = 1; m_pd = 0; m_slp = 1; m_cnt = 0;
        end else if (t) begin
            m_cnt = m_cnt + 1;
        end
        e.to = m_to; e.pd = m_pd; e.slp = m_slp; e.rst = rst; e.tag = tag;
        q.push_back(e);
    endtask

    // Monitor: compares design outputs against queued expectations.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            while (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                check(e.tag, "to_flag", int'(to_flag_o), int'(e.to));
                check(e.tag, "pd_flag", int'(pd_flag_o), int'(e.pd));
                check(e.tag, "sleeping", int'(sleeping_o), int'(e.slp));
                check(e.tag, "clk_en", int'(core_clk_en_o), int'(!e.slp));
                check(e.tag, "core_rst", int'(core_rst_o), int'(e.rst));
                check(e.tag, "pc_load", int'(pc_load_o), int'(e.rst));
                check(e.tag, "pc_vec", int'(pc_vec_o), 'h7FF);
            end
        end
    end

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        step(1, 0, 0, 0, 0, 14'h0000, "R1 power-on");
        step(0, 0, 0, 0, 0, 14'h0000, "R2 pulse ends");
        step(0, 0, 0, 0, 1, 14'h1000, "R9 nop");
        step(0, 0, 0, 0, 1, 14'h2001, "R9 other word");
        step(0, 0, 0, 0, 1, 14'h1002, "R8 sleep");
        step(0, 0, 0, 0, 1, 14'h1001, "R12 clrwdt asleep");
        step(0, 1, 0, 0, 0, 14'h0000, "R4 mclr asleep");
        step(0, 1, 0, 0, 0, 14'h0000, "R3 mclr awake");
        step(0, 0, 0, 0, 1, 14'h1001, "R7 clrwdt");
        step(0, 0, 1, 0, 0, 14'h0000, "R5 wdt awake");
        step(0, 1, 0, 0, 0, 14'h0000, "R3 mclr keeps 0,1");
        step(0, 0, 0, 0, 0, 14'h1001, "R12 not valid");
        step(0, 0, 0, 0, 1, 14'h1002, "R8 sleep again");
        step(0, 0, 1, 0, 0, 14'h0000, "R6 wdt asleep");
        step(0, 0, 0, 0, 1, 14'h1002, "R8 sleep for prio");
        step(0, 1, 1, 0, 0, 14'h0000, "R10 mclr beats wdt");
        step(0, 0, 1, 0, 0, 14'h0000, "R5 set 0,1");
        step(1, 1, 1, 0, 0, 14'h0000, "R10 por beats all");
        step(0, 0, 0, 0, 1, 14'h1001, "R7 clear count");
        for (int i = 0; i < 10; i++) step(0, 0, 0, 1, 0, 14'h0000, "R11 count");
        step(0, 0, 0, 1, 1, 14'h1001, "R7 tick with clear");
        for (int i = 0; i < 16; i++) step(0, 0, 0, 1, 0, 14'h0000, "R11 overflow awake");
        step(0, 0, 0, 0, 0, 14'h0000, "R2 after overflow");
        step(0, 0, 0, 0, 1, 14'h1002, "R8 sleep before ticks");
        for (int i = 0; i < 8; i++) step(0, 0, 0, 1, 1, 14'h1001, "R12 ignored asleep");
        for (int i = 0; i < 8; i++) step(0, 0, 0, 1, 0, 14'h0000, "R6 overflow asleep");
        step(0, 0, 0, 0, 0, 14'h0000, "R11 idle");
        @(negedge clk);
        @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule